// File: doc/BRIEF.md
# Dynamic Bank Colour Allocator

This block decides, once per profiling interval, which DRAM bank colours each core may use during the next interval. For every core it receives the number of memory accesses made in the interval that just ended and how many of those hit an open row. From these it sorts each core into one of three groups: light (non-intensive), intensive with poor row locality, or intensive with good row locality. It then builds a per-core colour bitmask from the mix of groups across all cores.

The total colour count is banks per rank times ranks. The partition unit (colours per core) is that total divided by the core count. Core `i` has a home set of colours `[i*MPU +: MPU]`. Each core keeps its home colours wherever the rules allow, so the banks it already holds stay with it.

Light cores are allowed every colour when at least one other core is intensive. Intensive cores with good locality are isolated on their home set. When the partition unit is below 16, intensive cores with poor locality are paired in ascending core order, and each pair pools its two home sets. If the partition unit is 16 or more, each of these cores keeps its private home set instead.

The statistics are sampled on an end-of-interval strobe. The decision is registered and held unchanged for the whole next interval.

Top module: `bank_color_alloc`

## Requirements
- R1: A core whose access count is below `intensity_thr` gets group code 0 (light); an access count equal to the threshold counts as intensive.
- R2: An intensive core gets group code 1 (poor locality) when `hit_cnt*256 < locality_thr*access_cnt`, with `locality_thr` an unsigned fraction in 1/256 units; otherwise it gets code 2 (good locality). A hit rate exactly at the threshold is code 2.
- R3: When no core is intensive, every core's mask is its home set, bits `[i*MPU +: MPU]` of its `color_mask` slice.
- R4: When at least one core is intensive, every light core's mask has all colour bits set.
- R5: A code-2 core's mask is always its home set.
- R6: With MPU below 16, code-1 cores are paired in ascending core index: the 1st with the 2nd, the 3rd with the 4th, and so on. Both members of a pair get the OR of their two home sets. This also holds when every core is intensive.
- R7: When the number of code-1 cores is odd, the highest-indexed one gets only its home set.
- R8: Outputs change only in the cycle after `interval_end` is sampled high and are otherwise held, whatever the statistics inputs do.
- R9: After synchronous reset every group code is 0 and every mask is its home set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_end | input | 1 | End-of-interval strobe; statistics are sampled when high |
| access_cnt | input | N_CORES*CNT_W | Per-core access count, core i at `[i*CNT_W +: CNT_W]` |
| hit_cnt | input | N_CORES*CNT_W | Per-core row-hit count, same layout |
| intensity_thr | input | CNT_W | Access count at or above which a core is intensive |
| locality_thr | input | 8 | Row-hit fraction threshold in 1/256 units |
| color_mask | output | N_CORES*N_COLORS | Per-core colour mask, core i at `[i*N_COLORS +: N_COLORS]` |
| group_code | output | N_CORES*2 | Per-core group code, core i at `[2*i +: 2]` |

## Verification
The assertions check a set of relationships on every cycle:
- no group code is ever 3;
- masks stay put between strobes;
- good-locality cores sit on their home set;
- light cores own every colour whenever some core is intensive;
- poor-locality masks hold one or two partition units;
- intensive cores with differing masks never overlap;
- an all-light mix is an equal split.

Two things need the bench's scenarios. The first is which cores get paired and with whom, which depends on the ascending-order rule. The second is the exact threshold edges of the classifier. The bench sweeps all 81 group mixes of four cores and also drives boundary statistics.

// File: rtl/bank_color_pkg.sv
package bank_color_pkg;

    localparam int GRP_W      = 2;
    localparam int LOC_FRAC_W = 8;

    typedef enum logic [GRP_W-1:0] {
        GRP_LIGHT = 2'd0,
        GRP_LOW   = 2'd1,
        GRP_HIGH  = 2'd2
    } grp_e;

endpackage

// File: rtl/bcolor_classifier.sv
module bcolor_classifier
    import bank_color_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]      acc,
    input  logic [CNT_W-1:0]      hits,
    input  logic [CNT_W-1:0]      thr_int,
    input  logic [LOC_FRAC_W-1:0] thr_loc,
    output grp_e                  grp
);
    localparam int PW = CNT_W + LOC_FRAC_W;

    logic [PW-1:0] hits_scaled;
    logic [PW-1:0] limit;

    // Cross-multiplied compare: hits/acc < thr/256 without a divider
    assign hits_scaled = {hits, {LOC_FRAC_W{1'b0}}};
    assign limit       = {{LOC_FRAC_W{1'b0}}, acc} * {{CNT_W{1'b0}}, thr_loc};

    always_comb begin
        if (acc < thr_int)
            grp = GRP_LIGHT;
        else if (hits_scaled < limit)
            grp = GRP_LOW;
        else
            grp = GRP_HIGH;
    end
endmodule

// File: rtl/bcolor_mask_builder.sv
module bcolor_mask_builder
    import bank_color_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_COLORS = 16
) (
    input  grp_e                         grp [N_CORES],
    output logic [N_COLORS*N_CORES-1:0]  masks
);
    localparam int MPU  = N_COLORS / N_CORES;
    localparam bit POOL = (MPU < 16);
    localparam logic [N_COLORS-1:0] UNIT = {{(N_COLORS-MPU){1'b0}}, {MPU{1'b1}}};

    logic               any_int;
    logic [N_CORES-1:0] has_partner;
    int                 partner [N_CORES];

    // Pair poor-locality cores in ascending index order
    always_comb begin
        int pend;
        pend    = -1;
        any_int = 1'b0;
        for (int i = 0; i < N_CORES; i++) begin
            has_partner[i] = 1'b0;
            partner[i]     = i;
        end
        for (int i = 0; i < N_CORES; i++) begin
            if (grp[i] != GRP_LIGHT)
                any_int = 1'b1;
            if (grp[i] == GRP_LOW) begin
                if (pend >= 0) begin
                    has_partner[pend] = 1'b1;
                    partner[pend]     = i;
                    has_partner[i]    = 1'b1;
                    partner[i]        = pend;
                    pend              = -1;
                end else begin
                    pend = i;
                end
            end
        end
    end

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic [N_COLORS-1:0] home;
        logic [N_COLORS-1:0] mate;
        assign home = UNIT << (c * MPU);
        assign mate = UNIT << (partner[c] * MPU);

        always_comb begin
            if (!any_int)
                masks[c*N_COLORS +: N_COLORS] = home;
            else begin
                case (grp[c])
                    GRP_LIGHT: masks[c*N_COLORS +: N_COLORS] = {N_COLORS{1'b1}};
                    GRP_LOW:   masks[c*N_COLORS +: N_COLORS] =
                                   (POOL && has_partner[c]) ? (home | mate) : home;
                    default:   masks[c*N_COLORS +: N_COLORS] = home;
                endcase
            end
        end
    end
endmodule

// File: rtl/bank_color_alloc.sv
module bank_color_alloc
    import bank_color_pkg::*;
#(
    parameter int N_CORES        = 4,
    parameter int BANKS_PER_RANK = 8,
    parameter int RANKS          = 2,
    parameter int CNT_W          = 16,
    parameter int N_COLORS       = BANKS_PER_RANK * RANKS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          interval_end,
    input  logic [N_CORES*CNT_W-1:0]      access_cnt,
    input  logic [N_CORES*CNT_W-1:0]      hit_cnt,
    input  logic [CNT_W-1:0]              intensity_thr,
    input  logic [LOC_FRAC_W-1:0]         locality_thr,
    output logic [N_CORES*N_COLORS-1:0]   color_mask,
    output logic [N_CORES*GRP_W-1:0]      group_code
);
    localparam int MPU = N_COLORS / N_CORES;
    localparam logic [N_COLORS-1:0] UNIT = {{(N_COLORS-MPU){1'b0}}, {MPU{1'b1}}};

    grp_e                          grp_d [N_CORES];
    logic [N_CORES*N_COLORS-1:0]   mask_d;

    for (genvar c = 0; c < N_CORES; c++) begin : g_cls
        bcolor_classifier #(.CNT_W(CNT_W)) u_cls (
            .acc     (access_cnt[c*CNT_W +: CNT_W]),
            .hits    (hit_cnt[c*CNT_W +: CNT_W]),
            .thr_int (intensity_thr),
            .thr_loc (locality_thr),
            .grp     (grp_d[c])
        );
    end

    bcolor_mask_builder #(.N_CORES(N_CORES), .N_COLORS(N_COLORS)) u_bld (
        .grp   (grp_d),
        .masks (mask_d)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                color_mask[c*N_COLORS +: N_COLORS] <= UNIT << (c * MPU);
                group_code[c*GRP_W +: GRP_W]       <= GRP_LIGHT;
            end else if (interval_end) begin
                color_mask[c*N_COLORS +: N_COLORS] <= mask_d[c*N_COLORS +: N_COLORS];
                group_code[c*GRP_W +: GRP_W]       <= grp_d[c];
            end
        end
    end
endmodule

// File: rtl/bank_color_alloc_chk.sv
module bank_color_alloc_chk #(
    parameter int N_CORES  = 4,
    parameter int N_COLORS = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         interval_end,
    input logic [N_CORES*N_COLORS-1:0]  color_mask,
    input logic [N_CORES*2-1:0]         group_code
);
    localparam int MPU = N_COLORS / N_CORES;
    localparam logic [N_COLORS-1:0] UNIT = {{(N_COLORS-MPU){1'b0}}, {MPU{1'b1}}};

    logic any_int;
    always_comb begin
        any_int = 1'b0;
        for (int i = 0; i < N_CORES; i++)
            if (group_code[2*i +: 2] != 2'd0) any_int = 1'b1;
    end

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !interval_end |=> ($stable(color_mask) && $stable(group_code))); // R8

    for (genvar c = 0; c < N_CORES; c++) begin : g_a
        AST_GROUP_LEGAL: assert property (@(posedge clk) disable iff (rst)
            group_code[2*c +: 2] != 2'd3); // R2
        AST_HIGH_HOME: assert property (@(posedge clk) disable iff (rst)
            group_code[2*c +: 2] == 2'd2 |->
            color_mask[c*N_COLORS +: N_COLORS] == (UNIT << (c*MPU))); // R5
        AST_LIGHT_ALL: assert property (@(posedge clk) disable iff (rst)
            (any_int && group_code[2*c +: 2] == 2'd0) |->
            &color_mask[c*N_COLORS +: N_COLORS]); // R4
        AST_EQUAL_SPLIT: assert property (@(posedge clk) disable iff (rst)
            !any_int |-> color_mask[c*N_COLORS +: N_COLORS] == (UNIT << (c*MPU))); // R3
        AST_LOW_SIZE: assert property (@(posedge clk) disable iff (rst)
            group_code[2*c +: 2] == 2'd1 |->
            ($countones(color_mask[c*N_COLORS +: N_COLORS]) == MPU ||
             $countones(color_mask[c*N_COLORS +: N_COLORS]) == 2*MPU)); // R6
        for (genvar d = c + 1; d < N_CORES; d++) begin : g_pair
            AST_DISJOINT: assert property (@(posedge clk) disable iff (rst)
                (group_code[2*c +: 2] != 2'd0 && group_code[2*d +: 2] != 2'd0 &&
                 color_mask[c*N_COLORS +: N_COLORS] != color_mask[d*N_COLORS +: N_COLORS]) |->
                ((color_mask[c*N_COLORS +: N_COLORS] & color_mask[d*N_COLORS +: N_COLORS]) == '0)); // R7
        end
    end
endmodule

bind bank_color_alloc bank_color_alloc_chk #(.N_CORES(N_CORES), .N_COLORS(N_COLORS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .interval_end (interval_end),
    .color_mask   (color_mask),
    .group_code   (group_code)
);

// File: tb/bank_color_alloc_test.sv
module bank_color_alloc_test;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int CW    = 16;
    localparam int NC    = 16;
    localparam int MPU   = NC / N;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              interval_end = 1'b0;
    logic [N*CW-1:0]   access_cnt = '0;
    logic [N*CW-1:0]   hit_cnt = '0;
    logic [CW-1:0]     intensity_thr = 16'd200;
    logic [7:0]        locality_thr = 8'd128;
    logic [N*NC-1:0]   color_mask;
    logic [N*2-1:0]    group_code;

    int tests = 0;
    int fails = 0;

    bank_color_alloc uut (
        .clk(clk), .rst(rst), .interval_end(interval_end),
        .access_cnt(access_cnt), .hit_cnt(hit_cnt),
        .intensity_thr(intensity_thr), .locality_thr(locality_thr),
        .color_mask(color_mask), .group_code(group_code)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic [NC-1:0] home(int c);
        return 16'h000F << (c * MPU);
    endfunction

    task automatic chk_mask(int c, logic [NC-1:0] exp, string req);
        tests++;
        if (color_mask[c*NC +: NC] !== exp) begin
            fails++;
            $display("FAIL %s core%0d mask got %h expected %h", req, c, color_mask[c*NC +: NC], exp);
        end
    endtask

    task automatic chk_grp(int c, logic [1:0] exp, string req);
        tests++;
        if (group_code[2*c +: 2] !== exp) begin
            fails++;
            $display("FAIL %s core%0d group got %0d expected %0d", req, c, group_code[2*c +: 2], exp);
        end
    endtask

    // group g: 0 light, 1 poor locality, 2 good locality
    task automatic set_core(int c, int g);
        case (g)
            0: begin access_cnt[c*CW +: CW] = 16'd199; hit_cnt[c*CW +: CW] = 16'd150; end
            1: begin access_cnt[c*CW +: CW] = 16'd300; hit_cnt[c*CW +: CW] = 16'd100; end
            default: begin access_cnt[c*CW +: CW] = 16'd300; hit_cnt[c*CW +: CW] = 16'd200; end
        endcase
    endtask

    task automatic strobe();
        interval_end = 1'b1;
        @(negedge clk);
        interval_end = 1'b0;
    endtask

    task automatic check_mix(int g0, int g1, int g2, int g3);
        int g [N];
        int lows [N];
        int nl;
        logic [NC-1:0] em [N];
        logic anyi;
        g[0] = g0; g[1] = g1; g[2] = g2; g[3] = g3;
        nl = 0; anyi = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (g[c] != 0) anyi = 1'b1;
            if (g[c] == 1) begin lows[nl] = c; nl++; end
        end
        for (int c = 0; c < N; c++) begin
            chk_grp(c, 2'(g[c]), g[c] == 0 ? "R1" : "R2");
            if (!anyi) em[c] = home(c);
            else if (g[c] == 0) em[c] = '1;
            else em[c] = home(c);
        end
        for (int r = 0; r + 1 < nl; r += 2) begin
            em[lows[r]]   = home(lows[r]) | home(lows[r+1]);
            em[lows[r+1]] = em[lows[r]];
        end
        for (int c = 0; c < N; c++) begin
            string req;
            if (!anyi) req = "R3";
            else if (g[c] == 0) req = "R4";
            else if (g[c] == 2) req = "R5";
            else if ((nl % 2 == 1) && c == lows[nl-1]) req = "R7";
            else req = "R6";
            chk_mask(c, em[c], req);
        end
        // R8: new statistics without a strobe must not move the outputs
        for (int c = 0; c < N; c++) set_core(c, (g[c] + 1) % 3);
        repeat (3) @(negedge clk);
        for (int c = 0; c < N; c++) chk_mask(c, em[c], "R8");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            chk_grp(c, 2'd0, "R9");
            chk_mask(c, home(c), "R9");
        end

        for (int code = 0; code < 81; code++) begin
            int g0, g1, g2, g3;
            g0 = code % 3; g1 = (code / 3) % 3; g2 = (code / 9) % 3; g3 = (code / 27) % 3;
            set_core(0, g0); set_core(1, g1); set_core(2, g2); set_core(3, g3);
            strobe();
            check_mix(g0, g1, g2, g3);
        end

        // Threshold edges (R1, R2)
        access_cnt[0*CW +: CW] = 16'd199; hit_cnt[0*CW +: CW] = 16'd0;
        access_cnt[1*CW +: CW] = 16'd200; hit_cnt[1*CW +: CW] = 16'd200;
        access_cnt[2*CW +: CW] = 16'd200; hit_cnt[2*CW +: CW] = 16'd99;
        access_cnt[3*CW +: CW] = 16'd200; hit_cnt[3*CW +: CW] = 16'd100;
        strobe();
        chk_grp(0, 2'd0, "R1");
        chk_grp(1, 2'd2, "R1");
        chk_grp(2, 2'd1, "R2");
        chk_grp(3, 2'd2, "R2");
        chk_mask(0, '1, "R4");
        chk_mask(2, home(2), "R7");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule